// File: doc/BRIEF.md
# Interrupt Entry and Return Sequencer

This block sits beside the instruction pipeline of a small 8-bit CPU core and takes control of it while an interrupt is entered or left. It holds one pending flag per interrupt source, a master enable flag, a count of how deeply handlers are nested and the stack pointer. When the current instruction completes and an eligible source is pending, the block runs a fixed sequence. It saves the status word and the 20-bit return address on a byte-wide stack. It then reads the source's four-byte vector entry, which holds the handler address and a register-bank adjustment code. Finally it hands the handler address to the program counter.

Two return operations undo the entry. One ends a maskable handler and the other ends the non-maskable handler. Both pop the five saved bytes and give back the return address and the status word. The master enable flag is restored from the popped status. Source 0 is the non-maskable source. While its handler runs, a second non-maskable request stays pending until the non-maskable return has run. A busy output holds instruction fetch for the whole of each sequence.

Top module: `isr_sequencer`

## Requirements
- R1: A pulse on `irq_req[i]` sets pending flag `il_pend[i]`. The flag stays set until source i is accepted, `il_clr[i]` is pulsed, or reset. If a request and a clear arrive in the same cycle, the request wins.
- R2: When the block is idle and `insn_done` is high, the lowest-numbered eligible source is accepted. Source 0 is eligible whenever it is pending and no non-maskable handler is active, whatever `imf` and `irq_en` hold. A source i>0 is eligible when it is pending, `irq_en[i]` is 1 and `imf` is 1.
- R3: Acceptance keeps `busy` high for exactly 12 cycles. At the accepting edge, `imf` is cleared and the accepted source's pending flag is cleared.
- R4: Busy cycles 2 to 6 of acceptance are writes. They go to `sp-1` down to `sp-5` and carry, in this order: status high byte {previous imf, `psw_cur[14:8]`}, status low byte `psw_cur[7:0]`, {4'h0, `pc_cur[19:16]`}, `pc_cur[15:8]` and `pc_cur[7:0]`. `sp` ends 5 lower. No write happens while the block is idle.
- R5: Busy cycles 7 to 10 of acceptance read addresses `VEC_BASE + 4*src + 0..3`. Read data returns one cycle after its address. The bytes are the handler address bits 19:16 (low nibble), 15:8 and 7:0, then the bank code. In busy cycle 12, `pc_load` pulses and `pc_next` holds the handler address.
- R6: During acceptance, `rbs` increases by bits 7:4 of the bank code, modulo 16.
- R7: `nest_cnt` increases by one on each acceptance and decreases by one on each return. It never changes while the block is idle.
- R8: `reti_req` or `retn_req` in an idle cycle starts a return that keeps `busy` high for 6 cycles. It reads `sp` to `sp+4` as PCL, PCH, PCE, status low and status high, and `sp` ends 5 higher. In the last busy cycle, `pc_load` and `psw_load` pulse with the popped address and status, and `imf` takes status bit 15.
- R9: Only the return started by `retn_req` ends the non-maskable handler. A return request takes precedence over an acceptance in the same idle cycle.
- R10: While `busy` is high, `insn_done`, `reti_req`, `retn_req` and `imf_wr` are ignored.
- R11: After reset the block is idle, `imf`, `il_pend`, `rbs` and `nest_cnt` are 0, and `sp` equals `SP_INIT`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, one machine cycle per cycle |
| rst_n | input | 1 | Asynchronous active-low reset |
| irq_req | input | N_SRC | Request pulses, one per source; source 0 is non-maskable |
| irq_en | input | N_SRC | Per-source enables; bit 0 is not used for eligibility |
| il_clr | input | N_SRC | Explicit clear of pending flags |
| imf_wr | input | 1 | Write strobe for the master enable flag |
| imf_wdata | input | 1 | Value written to the master enable flag |
| insn_done | input | 1 | The current instruction completes this cycle |
| reti_req | input | 1 | Start the return from a maskable handler |
| retn_req | input | 1 | Start the return from the non-maskable handler |
| pc_cur | input | 20 | Return address to save |
| psw_cur | input | 15 | Status bits other than the master enable flag |
| mem_addr | output | 16 | Stack/vector memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_wdata | output | 8 | Memory write byte |
| mem_rdata | input | 8 | Memory read byte, valid one cycle after its address |
| busy | output | 1 | Holds instruction fetch during a sequence |
| pc_load | output | 1 | Program counter load pulse |
| pc_next | output | 20 | Value for the program counter |
| psw_load | output | 1 | Status word restore pulse |
| psw_next | output | 16 | Restored status word, master enable in bit 15 |
| imf | output | 1 | Master enable flag |
| rbs | output | 4 | Register bank selector |
| nest_cnt | output | NEST_W | Nesting depth |
| il_pend | output | N_SRC | Pending flags |
| sp | output | 16 | Stack pointer |

## Verification
The assertions assume the memory behind the port answers a read in the next cycle, and that each sequence is started from an idle cycle. Under that assumption every busy run is 12 or 6 cycles long and is followed by at least one idle cycle. They also assume that `imf_wr` cannot change the master enable flag during a push. The stimulus drives requests, clears and control strobes as one-cycle pulses at the falling edge. It gives returns only after a matching entry, so pops always read bytes that a push wrote. It deliberately fires strobes during busy sequences to show that they have no effect.

// File: rtl/isr_pkg.sv
package isr_pkg;

  typedef enum logic [1:0] {
    MODE_IDLE = 2'd0,
    MODE_ACC  = 2'd1,
    MODE_RET  = 2'd2
  } isr_mode_e;

  localparam int unsigned ACC_CYCLES = 12;
  localparam int unsigned RET_CYCLES = 6;
  localparam int unsigned PC_W       = 20;
  localparam int unsigned ADDR_W     = 16;
  localparam int unsigned STEP_W     = 4;
  localparam int unsigned PUSH_FIRST = 1;
  localparam int unsigned PUSH_LAST  = 5;
  localparam int unsigned VRD_FIRST  = 6;
  localparam int unsigned VRD_LAST   = 9;
  localparam int unsigned BANK_STEP  = 10;

endpackage

// File: rtl/irq_latch_bank.sv
module irq_latch_bank #(
  parameter int unsigned N_SRC = 4,
  parameter int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SRC-1:0] req,
  input  logic [N_SRC-1:0] clr,
  input  logic [N_SRC-1:0] take,
  input  logic [N_SRC-1:0] en,
  input  logic             imf,
  input  logic             nmi_busy,
  output logic [N_SRC-1:0] pend,
  output logic             win_vld,
  output logic [IDX_W-1:0] win_idx
);

  logic [N_SRC-1:0] pend_d;
  logic [N_SRC-1:0] elig;

  // request wins over a clear in the same cycle
  always_comb begin
    pend_d = (pend & ~clr & ~take) | req;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend <= '0;
    end else begin
      pend <= pend_d;
    end
  end

  for (genvar gi = 0; gi < N_SRC; gi++) begin : g_elig
    if (gi == 0) begin : g_nmi
      assign elig[gi] = pend[gi] & ~nmi_busy;
    end else begin : g_mask
      assign elig[gi] = pend[gi] & en[gi] & imf;
    end
  end

  // lowest index wins
  always_comb begin
    win_vld = 1'b0;
    win_idx = '0;
    for (int i = N_SRC - 1; i >= 0; i--) begin
      if (elig[i]) begin
        win_vld = 1'b1;
        win_idx = IDX_W'(i);
      end
    end
  end

endmodule

// File: rtl/isr_seq_core.sv
module isr_seq_core
  import isr_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned IDX_W    = 2,
  parameter int unsigned NEST_W   = 4,
  parameter logic [15:0] VEC_BASE = 16'h0F00,
  parameter logic [15:0] SP_INIT  = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              insn_done,
  input  logic              reti_req,
  input  logic              retn_req,
  input  logic              imf_wr,
  input  logic              imf_wdata,
  input  logic [PC_W-1:0]   pc_cur,
  input  logic [14:0]       psw_cur,
  input  logic              win_vld,
  input  logic [IDX_W-1:0]  win_idx,
  output logic [N_SRC-1:0]  take,
  output logic              imf,
  output logic              nmi_busy,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              pc_load,
  output logic [PC_W-1:0]   pc_next,
  output logic              psw_load,
  output logic [15:0]       psw_next,
  output logic [3:0]        rbs,
  output logic [NEST_W-1:0] nest_cnt,
  output logic [ADDR_W-1:0] sp
);

  isr_mode_e         mode_q, mode_d;
  logic [STEP_W-1:0] step_q, step_d;
  logic [IDX_W-1:0]  src_q, src_d;
  logic              retn_q, retn_d;
  logic              imf_q, imf_d;
  logic              nmib_q, nmib_d;
  logic [ADDR_W-1:0] sp_q, sp_d;
  logic [3:0]        rbs_q, rbs_d;
  logic [NEST_W-1:0] nest_q, nest_d;
  logic [PC_W-1:0]   pcsv_q, pcsv_d;
  logic [15:0]       pswsv_q, pswsv_d;
  logic [7:0]        bq_q [4];
  logic [7:0]        bq_d [4];
  logic              idle, ret_go, acc_go, step_adv;
  logic [ADDR_W-1:0] vec_addr;

  assign idle     = (mode_q == MODE_IDLE);
  assign ret_go   = idle & (reti_req | retn_req);
  assign acc_go   = idle & ~ret_go & insn_done & win_vld;
  assign step_adv = ~idle;
  assign vec_addr = VEC_BASE + (ADDR_W'(src_q) << 2);

  always_comb begin
    take = '0;
    if (acc_go) take[win_idx] = 1'b1;
  end

  // next-state process
  always_comb begin
    mode_d  = mode_q;
    step_d  = step_q;
    src_d   = src_q;
    retn_d  = retn_q;
    imf_d   = imf_q;
    nmib_d  = nmib_q;
    sp_d    = sp_q;
    rbs_d   = rbs_q;
    nest_d  = nest_q;
    pcsv_d  = pcsv_q;
    pswsv_d = pswsv_q;
    for (int k = 0; k < 4; k++) bq_d[k] = bq_q[k];
    if (step_adv) step_d = step_q + STEP_W'(1);

    unique case (mode_q)
      MODE_IDLE: begin
        if (ret_go) begin
          mode_d = MODE_RET;
          step_d = '0;
          retn_d = retn_req;
        end else if (acc_go) begin
          mode_d  = MODE_ACC;
          step_d  = '0;
          src_d   = win_idx;
          imf_d   = 1'b0;
          pcsv_d  = pc_cur;
          pswsv_d = {imf_q, psw_cur};
          if (win_idx == '0) nmib_d = 1'b1;
        end else if (imf_wr) begin
          imf_d = imf_wdata;
        end
      end
      MODE_ACC: begin
        if (step_q >= STEP_W'(PUSH_FIRST) && step_q <= STEP_W'(PUSH_LAST))
          sp_d = sp_q - ADDR_W'(1);
        if (step_q > STEP_W'(VRD_FIRST) && step_q <= STEP_W'(VRD_LAST))
          bq_d[2'(step_q - STEP_W'(VRD_FIRST + 1))] = mem_rdata;
        if (step_q == STEP_W'(BANK_STEP)) begin
          rbs_d  = rbs_q + mem_rdata[7:4];
          nest_d = nest_q + NEST_W'(1);
        end
        if (step_q == STEP_W'(ACC_CYCLES - 1)) begin
          mode_d = MODE_IDLE;
          step_d = '0;
        end
      end
      MODE_RET: begin
        if (step_q < STEP_W'(RET_CYCLES - 1))
          sp_d = sp_q + ADDR_W'(1);
        if (step_q >= STEP_W'(1) && step_q < STEP_W'(RET_CYCLES - 1))
          bq_d[2'(step_q - STEP_W'(1))] = mem_rdata;
        if (step_q == STEP_W'(RET_CYCLES - 1)) begin
          mode_d = MODE_IDLE;
          step_d = '0;
          imf_d  = mem_rdata[7];
          nest_d = nest_q - NEST_W'(1);
          if (retn_q) nmib_d = 1'b0;
        end
      end
      default: mode_d = MODE_IDLE;
    endcase
  end

  // register process
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q  <= MODE_IDLE;
      step_q  <= '0;
      src_q   <= '0;
      retn_q  <= 1'b0;
      imf_q   <= 1'b0;
      nmib_q  <= 1'b0;
      sp_q    <= SP_INIT;
      rbs_q   <= '0;
      nest_q  <= '0;
      pcsv_q  <= '0;
      pswsv_q <= '0;
      for (int k = 0; k < 4; k++) bq_q[k] <= '0;
    end else begin
      mode_q  <= mode_d;
      step_q  <= step_d;
      src_q   <= src_d;
      retn_q  <= retn_d;
      imf_q   <= imf_d;
      nmib_q  <= nmib_d;
      sp_q    <= sp_d;
      rbs_q   <= rbs_d;
      nest_q  <= nest_d;
      pcsv_q  <= pcsv_d;
      pswsv_q <= pswsv_d;
      for (int k = 0; k < 4; k++) bq_q[k] <= bq_d[k];
    end
  end

  // memory port and load outputs
  always_comb begin
    mem_addr  = sp_q;
    mem_we    = 1'b0;
    mem_wdata = '0;
    pc_load   = 1'b0;
    pc_next   = '0;
    psw_load  = 1'b0;
    psw_next  = '0;
    if (mode_q == MODE_ACC) begin
      if (step_q >= STEP_W'(PUSH_FIRST) && step_q <= STEP_W'(PUSH_LAST)) begin
        mem_we   = 1'b1;
        mem_addr = sp_q - ADDR_W'(1);
        unique case (step_q)
          STEP_W'(1): mem_wdata = pswsv_q[15:8];
          STEP_W'(2): mem_wdata = pswsv_q[7:0];
          STEP_W'(3): mem_wdata = {4'h0, pcsv_q[19:16]};
          STEP_W'(4): mem_wdata = pcsv_q[15:8];
          default:    mem_wdata = pcsv_q[7:0];
        endcase
      end else if (step_q >= STEP_W'(VRD_FIRST) && step_q <= STEP_W'(VRD_LAST)) begin
        mem_addr = vec_addr + ADDR_W'(step_q - STEP_W'(VRD_FIRST));
      end
      if (step_q == STEP_W'(ACC_CYCLES - 1)) begin
        pc_load = 1'b1;
        pc_next = {bq_q[0][3:0], bq_q[1], bq_q[2]};
      end
    end else if (mode_q == MODE_RET) begin
      if (step_q == STEP_W'(RET_CYCLES - 1)) begin
        pc_load  = 1'b1;
        pc_next  = {bq_q[2][3:0], bq_q[1], bq_q[0]};
        psw_load = 1'b1;
        psw_next = {mem_rdata, bq_q[3]};
      end
    end
  end

  assign busy     = ~idle;
  assign imf      = imf_q;
  assign nmi_busy = nmib_q;
  assign sp       = sp_q;
  assign rbs      = rbs_q;
  assign nest_cnt = nest_q;

endmodule

// File: rtl/isr_sequencer.sv
module isr_sequencer
  import isr_pkg::*;
#(
  parameter int unsigned N_SRC    = 4,
  parameter int unsigned NEST_W   = 4,
  parameter logic [15:0] VEC_BASE = 16'h0F00,
  parameter logic [15:0] SP_INIT  = 16'h0800
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [N_SRC-1:0]  irq_req,
  input  logic [N_SRC-1:0]  irq_en,
  input  logic [N_SRC-1:0]  il_clr,
  input  logic              imf_wr,
  input  logic              imf_wdata,
  input  logic              insn_done,
  input  logic              reti_req,
  input  logic              retn_req,
  input  logic [19:0]       pc_cur,
  input  logic [14:0]       psw_cur,
  output logic [15:0]       mem_addr,
  output logic              mem_we,
  output logic [7:0]        mem_wdata,
  input  logic [7:0]        mem_rdata,
  output logic              busy,
  output logic              pc_load,
  output logic [19:0]       pc_next,
  output logic              psw_load,
  output logic [15:0]       psw_next,
  output logic              imf,
  output logic [3:0]        rbs,
  output logic [NEST_W-1:0] nest_cnt,
  output logic [N_SRC-1:0]  il_pend,
  output logic [15:0]       sp
);

  localparam int unsigned IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1;

  logic [N_SRC-1:0] take;
  logic             win_vld;
  logic [IDX_W-1:0] win_idx;
  logic             nmi_busy;

  irq_latch_bank #(.N_SRC(N_SRC), .IDX_W(IDX_W)) u_latch (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (irq_req),
    .clr      (il_clr),
    .take     (take),
    .en       (irq_en),
    .imf      (imf),
    .nmi_busy (nmi_busy),
    .pend     (il_pend),
    .win_vld  (win_vld),
    .win_idx  (win_idx)
  );

  isr_seq_core #(
    .N_SRC(N_SRC), .IDX_W(IDX_W), .NEST_W(NEST_W),
    .VEC_BASE(VEC_BASE), .SP_INIT(SP_INIT)
  ) u_core (
    .clk       (clk),
    .rst_n     (rst_n),
    .insn_done (insn_done),
    .reti_req  (reti_req),
    .retn_req  (retn_req),
    .imf_wr    (imf_wr),
    .imf_wdata (imf_wdata),
    .pc_cur    (pc_cur),
    .psw_cur   (psw_cur),
    .win_vld   (win_vld),
    .win_idx   (win_idx),
    .take      (take),
    .imf       (imf),
    .nmi_busy  (nmi_busy),
    .mem_addr  (mem_addr),
    .mem_we    (mem_we),
    .mem_wdata (mem_wdata),
    .mem_rdata (mem_rdata),
    .busy      (busy),
    .pc_load   (pc_load),
    .pc_next   (pc_next),
    .psw_load  (psw_load),
    .psw_next  (psw_next),
    .rbs       (rbs),
    .nest_cnt  (nest_cnt),
    .sp        (sp)
  );

endmodule

// File: rtl/isr_sequencer_chk.sv
module isr_sequencer_chk #(
  parameter int unsigned NEST_W = 4
) (
  input logic              clk,
  input logic              rst_n,
  input logic              busy,
  input logic              mem_we,
  input logic [15:0]       sp,
  input logic              pc_load,
  input logic              psw_load,
  input logic              imf,
  input logic [NEST_W-1:0] nest_cnt
);

  logic [4:0] run_len;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_len <= '0;
    end else if (busy) begin
      if (run_len != 5'd31) run_len <= run_len + 5'd1;
    end else begin
      run_len <= '0;
    end
  end

  AST_BUSY_RUN_LEN: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && run_len != 5'd0) |-> (run_len == 5'd12 || run_len == 5'd6)); // R3

  AST_PUSH_PREDEC: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |=> (sp == $past(sp) - 16'd1)); // R4

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_we); // R4

  AST_PUSH_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    mem_we |-> !imf); // R3

  AST_LOAD_ENDS_SEQ: assert property (@(posedge clk) disable iff (!rst_n)
    pc_load |=> !busy); // R5

  AST_PSW_WITH_PC: assert property (@(posedge clk) disable iff (!rst_n)
    psw_load |-> pc_load); // R8

  AST_NEST_IDLE_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> $stable(nest_cnt)); // R7

endmodule

bind isr_sequencer isr_sequencer_chk #(.NEST_W(NEST_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .busy     (busy),
  .mem_we   (mem_we),
  .sp       (sp),
  .pc_load  (pc_load),
  .psw_load (psw_load),
  .imf      (imf),
  .nest_cnt (nest_cnt)
);

// File: tb/isr_sequencer_bench.sv
`timescale 1ns/1ps
module isr_sequencer_bench;

  localparam int          N   = 4;
  localparam logic [15:0] VB  = 16'h0F00;
  localparam logic [15:0] SPI = 16'h0800;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [N-1:0] irq_req = '0, irq_en = 4'b1110, il_clr = '0;
  logic imf_wr = 1'b0, imf_wdata = 1'b0, insn_done = 1'b0;
  logic reti_req = 1'b0, retn_req = 1'b0;
  logic [19:0] pc_cur = '0;
  logic [14:0] psw_cur = '0;
  logic [15:0] mem_addr, psw_next, sp;
  logic mem_we, busy, pc_load, psw_load, imf;
  logic [7:0] mem_wdata;
  logic [7:0] mem_rdata = '0;
  logic [19:0] pc_next;
  logic [3:0] rbs, nest_cnt;
  logic [N-1:0] il_pend;

  logic [7:0] mem [0:4095];

  int n_cmp = 0, n_bad = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  isr_sequencer u_isr_sequencer (
    .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .irq_en(irq_en), .il_clr(il_clr),
    .imf_wr(imf_wr), .imf_wdata(imf_wdata), .insn_done(insn_done),
    .reti_req(reti_req), .retn_req(retn_req), .pc_cur(pc_cur), .psw_cur(psw_cur),
    .mem_addr(mem_addr), .mem_we(mem_we), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .busy(busy), .pc_load(pc_load), .pc_next(pc_next), .psw_load(psw_load),
    .psw_next(psw_next), .imf(imf), .rbs(rbs), .nest_cnt(nest_cnt),
    .il_pend(il_pend), .sp(sp)
  );

  // memory with one-cycle read latency
  always @(posedge clk) begin
    if (mem_we) mem[mem_addr[11:0]] <= mem_wdata;
    mem_rdata <= mem[mem_addr[11:0]];
  end

  // reference model state
  int m_mode, m_step, m_src;
  bit [N-1:0] m_lat;
  bit m_imf, m_nmib, m_retn;
  logic [15:0] m_sp;
  logic [3:0] m_rbs, m_nest;
  logic [7:0] m_pswh, m_pswl, m_code;
  logic [19:0] m_pc, m_vpc;
  logic [7:0] m_pop [5];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic int winner();
    for (int i = 0; i < N; i++) begin
      if (i == 0 && m_lat[0] && !m_nmib) return 0;
      if (i > 0 && m_lat[i] && irq_en[i] && m_imf) return i;
    end
    return -1;
  endfunction

  task automatic model_step();
    int w;
    bit [N-1:0] tk;
    w  = winner();
    tk = '0;
    case (m_mode)
      0: begin
        if (reti_req || retn_req) begin
          m_mode = 2; m_step = 0; m_retn = retn_req;
          for (int k = 0; k < 5; k++) m_pop[k] = mem[12'(m_sp + 16'(k))];
        end else if (insn_done && w >= 0) begin
          m_mode = 1; m_step = 0; m_src = w; tk[w] = 1'b1;
          m_pswh = {m_imf, psw_cur[14:8]}; m_pswl = psw_cur[7:0]; m_pc = pc_cur;
          m_imf = 1'b0;
          if (w == 0) m_nmib = 1'b1;
          m_vpc  = {mem[12'(VB + 16'(4*w))][3:0], mem[12'(VB + 16'(4*w+1))],
                    mem[12'(VB + 16'(4*w+2))]};
          m_code = mem[12'(VB + 16'(4*w+3))];
        end else if (imf_wr) begin
          m_imf = imf_wdata;
        end
      end
      1: begin
        if (m_step >= 1 && m_step <= 5) m_sp = m_sp - 16'd1;
        if (m_step == 10) begin m_rbs = m_rbs + m_code[7:4]; m_nest = m_nest + 4'd1; end
        if (m_step == 11) m_mode = 0; else m_step++;
      end
      default: begin
        if (m_step <= 4) m_sp = m_sp + 16'd1;
        if (m_step == 5) begin
          m_mode = 0; m_imf = m_pop[4][7]; m_nest = m_nest - 4'd1;
          if (m_retn) m_nmib = 1'b0;
        end else m_step++;
      end
    endcase
    m_lat = (m_lat & ~il_clr & ~tk) | irq_req;
  endtask

  task automatic compare_all();
    logic [7:0] wexp;
    if (!rst_n) begin
      chk("R11 busy", 32'(busy), 32'd0);
      chk("R11 imf", 32'(imf), 32'd0);
      chk("R11 il_pend", 32'(il_pend), 32'd0);
      chk("R11 sp", 32'(sp), 32'(SPI));
      chk("R11 rbs/nest", {rbs, nest_cnt}, 32'd0);
      return;
    end
    chk("R2/R3/R8/R9/R10 busy", 32'(busy), 32'(m_mode != 0));
    chk("R4 mem_we", 32'(mem_we), 32'(m_mode == 1 && m_step >= 1 && m_step <= 5));
    if (m_mode == 1 && m_step >= 1 && m_step <= 5) begin
      case (m_step)
        1: wexp = m_pswh;
        2: wexp = m_pswl;
        3: wexp = {4'h0, m_pc[19:16]};
        4: wexp = m_pc[15:8];
        default: wexp = m_pc[7:0];
      endcase
      chk("R4 push addr", 32'(mem_addr), 32'(m_sp - 16'd1));
      chk("R4 push data", 32'(mem_wdata), 32'(wexp));
    end
    if (m_mode == 1 && m_step >= 6 && m_step <= 9)
      chk("R5 vector addr", 32'(mem_addr), 32'(VB + 16'(4*m_src + m_step - 6)));
    if (m_mode == 2 && m_step <= 4)
      chk("R8 pop addr", 32'(mem_addr), 32'(m_sp));
    chk("R5/R8 pc_load", 32'(pc_load), 32'((m_mode == 1 && m_step == 11) || (m_mode == 2 && m_step == 5)));
    if (m_mode == 1 && m_step == 11) chk("R5 pc_next", 32'(pc_next), 32'(m_vpc));
    chk("R8 psw_load", 32'(psw_load), 32'(m_mode == 2 && m_step == 5));
    if (m_mode == 2 && m_step == 5) begin
      chk("R8 pc_next", 32'(pc_next), 32'({m_pop[2][3:0], m_pop[1], m_pop[0]}));
      chk("R8 psw_next", 32'(psw_next), 32'({m_pop[4], m_pop[3]}));
    end
    chk("R3/R8/R10 imf", 32'(imf), 32'(m_imf));
    chk("R6 rbs", 32'(rbs), 32'(m_rbs));
    chk("R7 nest_cnt", 32'(nest_cnt), 32'(m_nest));
    chk("R4/R8 sp", 32'(sp), 32'(m_sp));
    chk("R1/R2 il_pend", 32'(il_pend), 32'(m_lat));
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode = 0; m_step = 0; m_src = 0; m_lat = '0; m_imf = 0; m_nmib = 0; m_retn = 0;
      m_sp = SPI; m_rbs = '0; m_nest = '0;
    end else begin
      model_step();
    end
    #5;
    if (!done) compare_all();
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse_req(input logic [N-1:0] r, input logic [N-1:0] c);
    @(negedge clk); irq_req = r; il_clr = c;
    @(negedge clk); irq_req = '0; il_clr = '0;
  endtask

  task automatic pulse_done(input logic [19:0] pc, input logic [14:0] ps);
    @(negedge clk); insn_done = 1'b1; pc_cur = pc; psw_cur = ps;
    @(negedge clk); insn_done = 1'b0;
  endtask

  task automatic pulse_ret(input bit nmi);
    @(negedge clk); if (nmi) retn_req = 1'b1; else reti_req = 1'b1;
    @(negedge clk); retn_req = 1'b0; reti_req = 1'b0;
  endtask

  task automatic write_imf(input logic v);
    @(negedge clk); imf_wr = 1'b1; imf_wdata = v;
    @(negedge clk); imf_wr = 1'b0;
  endtask

  initial begin
    for (int a = 0; a < 4096; a++) mem[a] = 8'(a * 7 + 3);
    for (int i = 0; i < N; i++) begin
      mem[12'(VB + 16'(4*i))]   = 8'(8'hA0 | i);
      mem[12'(VB + 16'(4*i+1))] = 8'(8'h10 + i);
      mem[12'(VB + 16'(4*i+2))] = 8'(8'h40 + 8'(i*5));
      mem[12'(VB + 16'(4*i+3))] = 8'({4'(i*3 + 5), 4'(i)});
    end
    cyc(3);
    rst_n = 1'b1;
    cyc(2);
    // R2 R3 R4 R5 R6 R7: maskable entry of source 2
    write_imf(1'b1);
    pulse_req(4'b0100, '0);
    pulse_done(20'hA1234, 15'h3C5A);
    cyc(14);
    // R2: masked source waits, non-maskable source nests
    pulse_req(4'b0010, '0);
    pulse_done(20'h51111, 15'h0101);
    pulse_req(4'b0001, '0);
    pulse_done(20'h52222, 15'h7F00);
    // R10: strobes during busy are ignored
    cyc(2);
    @(negedge clk); reti_req = 1'b1; imf_wr = 1'b1; imf_wdata = 1'b1; insn_done = 1'b1;
    @(negedge clk); reti_req = 1'b0; imf_wr = 1'b0; insn_done = 1'b0;
    cyc(12);
    // R9: second non-maskable request blocked until RETN
    pulse_req(4'b0001, '0);
    pulse_done(20'h63333, 15'h0002);
    cyc(2);
    pulse_ret(1'b1);
    cyc(7);
    pulse_done(20'h64444, 15'h0003);
    cyc(14);
    pulse_ret(1'b1);
    cyc(7);
    // R8: maskable return restores imf, then pending source 1 is taken
    pulse_ret(1'b0);
    cyc(7);
    pulse_done(20'h75555, 15'h1234);
    cyc(14);
    pulse_ret(1'b0);
    cyc(7);
    // R1: explicit clear, and request beating a same-cycle clear
    pulse_req(4'b0100, '0);
    pulse_req('0, 4'b0100);
    pulse_done(20'h86666, 15'h0000);
    cyc(3);
    pulse_req(4'b1000, 4'b1000);
    pulse_req(4'b0010, '0);
    // R2: source 1 beats source 3
    pulse_done(20'h97777, 15'h4321);
    cyc(14);
    // R9: return precedence over a pending acceptance
    @(negedge clk); reti_req = 1'b1; insn_done = 1'b1;
    @(negedge clk); reti_req = 1'b0; insn_done = 1'b0;
    cyc(8);
    pulse_done(20'hA8888, 15'h0F0F);
    cyc(14);
    pulse_ret(1'b0);
    cyc(8);
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

endmodule